// File: doc/BRIEF.md
# Bidirectional Reset Pin Sequencer

This block owns the open-drain reset pin of a microcontroller and the reset that goes out to the other on-chip modules. It takes three kinds of reset request: power-on (the block's own synchronous reset input), an internal request pulse from logic such as a watchdog, and an external device pulling the shared pin low. Any of them starts an assertion period. During that period the block pulls the pin low and holds the modules in reset. It then releases the pin and checks, in two stages, that the pull-up has brought the line high. Only after that does it hand the external bus to the processor and pulse a start for the reset-vector fetch.

After power-on the block keeps the pin low until the clock source reports lock. A mode input marks the clock as supplied from outside, and that mode skips the wait. The pin input passes through a two-flop synchronizer before any decision is made on it. The block never drives the pin high. A configuration word is captured once, on the cycle the pin is let go. A sticky cause register records which kinds of reset have happened since software last cleared it.

Top module: `rst_pin_seq`

## Requirements
- R1: While `rst_n` is low, and afterwards until `pll_lock` or `ext_clk_mode` is high at a clock edge, `pin_oe` is 1, `sys_rst_n` is 0, `bus_en` is 0 and `fetch_start` is 0. The `rst_n` reset also loads `cause` with 3'b001.
- R2: With `ext_clk_mode` high, the assertion period starts on the first clock edge after `rst_n` goes high, whatever the state of `pll_lock`.
- R3: An assertion period keeps `pin_oe` high for exactly 512 cycles (ASSERT_CYC), counted from the edge that starts it. `pin_oe` then falls, which releases the pin.
- R4: `cfg_q` takes the value of `cfg_in` at the release edge and holds it until the next release. Changes to `cfg_in` at any other time do not reach `cfg_q`.
- R5: If the synchronized pin is high at the edge 10 cycles (SETTLE_CYC) after release, `bus_en` goes high and `fetch_start` is high for exactly one cycle, both at that edge.
- R6: If that first sample reads low, the pin is sampled again 180 cycles (RECHECK_CYC) later, at release + 190. A high reading there gives `bus_en` and the one-cycle `fetch_start` at that edge.
- R7: If the second sample also reads low, a new assertion period starts at release + 190, and bit 2 of `cause` (external) is set.
- R8: While the bus is released, an `int_req` that is high at an edge starts an assertion period at that edge and sets bit 1 of `cause` (internal).
- R9: While the bus is released, a low on `pin_in` starts an assertion period on the third edge after the pin falls (two synchronizer stages, then the decision), and sets bit 2 of `cause`.
- R10: `int_req` is ignored outside the released state. It does not change the timing of the running sequence and does not set `cause` bit 1.
- R11: The `cause` bits are sticky: bit 0 is power-on, bit 1 is internal and bit 2 is external. A `cause_clr` high at an edge clears all bits except one being set at that same edge, which is set.
- R12: `sys_rst_n` is low whenever `pin_oe` is high, and each low period of `sys_rst_n` lasts at least 4 cycles. `bus_en` is high only after a passing pin sample and never while `pin_oe` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| pll_lock | input | 1 | Clock synthesizer lock indication, synchronous to clk |
| ext_clk_mode | input | 1 | 1 = clock supplied externally, skip the lock wait |
| int_req | input | 1 | Internal reset request, sampled at each edge |
| pin_in | input | 1 | Level read back from the reset pin |
| cfg_in | input | CFG_W (4) | Configuration word captured at pin release |
| cause_clr | input | 1 | Clears the sticky cause bits |
| pin_oe | output | 1 | 1 = pull the reset pin low; 0 = let it float |
| sys_rst_n | output | 1 | Active-low reset to the other on-chip modules |
| bus_en | output | 1 | External bus handed to the processor |
| fetch_start | output | 1 | One-cycle start of the reset-vector fetch |
| cfg_q | output | CFG_W (4) | Configuration captured at the last release |
| cause | output | 3 | Sticky reset causes: bit0 power-on, bit1 internal, bit2 external |

## Verification
Each result has a fixed due cycle, counted from the edge that caused it. An internal request starts the assertion on the same edge. A falling pin starts it three edges later. The release comes 512 edges after the start, the first sample 10 edges after release, and the second sample 190 edges after release. The driver works out these edge numbers from the requirements at the moment it applies each stimulus and queues the expected pin-release, pin-assert and fetch events. A monitor samples at the falling clock edge, stamps every edge it sees with the count of rising edges so far, and requires the kind and the cycle to match the head of the queue. An event the queue does not hold, or one at the wrong cycle, is a failure. The cause and configuration outputs are read at quiet points after each sequence has finished.

// File: rtl/rst_seq_pkg.sv
// Package: shared state encoding and cause-bit positions for the reset
// pin sequencer. Assumes a single clock domain for all users.
package rst_seq_pkg;

    typedef enum logic [2:0] {
        ST_LOCK    = 3'd0,  // power-on: pin held, waiting for clock lock
        ST_ASSERT  = 3'd1,  // timed pin assertion
        ST_SETTLE  = 3'd2,  // pin released, short wait before first sample
        ST_RECHECK = 3'd3,  // long wait before second sample
        ST_RUN     = 3'd4   // bus released, normal operation
    } seq_state_t;

    localparam int CAUSE_W   = 3;
    localparam int CAUSE_POR = 0;
    localparam int CAUSE_INT = 1;
    localparam int CAUSE_EXT = 2;

endpackage

// File: rtl/rst_pin_sync.sv
// Module: multi-stage synchronizer for the reset pin level.
// Assumes the input may change at any time relative to clk; the output
// resets low, which the sequencer treats as "pin held".
module rst_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic d_out
);

    logic [STAGES-1:0] chain_q;

    // Shift the pin level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d_in};
        end
    end

    assign d_out = chain_q[STAGES-1];

endmodule

// File: rtl/rst_win_timer.sv
// Module: window timer. Counts edges since the last restart and flags the
// edge on which the count equals the supplied last value.
// Assumes restart is raised on every state change; saturates when idle.
module rst_win_timer #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [CNT_W-1:0] last,
    output logic             done
);

    logic [CNT_W-1:0] cnt_q;

    // Count up from zero after each restart, holding at the top value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (cnt_q != {CNT_W{1'b1}}) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = (cnt_q == last);

endmodule

// File: rtl/rst_cause_reg.sv
// Module: sticky reset-cause bits. A set request wins over a clear in the
// same cycle; reset loads the power-on bit.
// Assumes set and clr are single-cycle synchronous strobes.
module rst_cause_reg #(
    parameter int W = 3,
    parameter int POR_BIT = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set,
    input  logic         clr,
    output logic [W-1:0] cause
);

    localparam logic [W-1:0] POR_VAL = W'(1) << POR_BIT;

    logic [W-1:0] cause_q;

    // Accumulate causes; a clear keeps only the bits set this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause_q <= POR_VAL;
        end else if (clr) begin
            cause_q <= set;
        end else begin
            cause_q <= cause_q | set;
        end
    end

    assign cause = cause_q;

endmodule

// File: rtl/rst_pin_seq.sv
// Module: bidirectional reset pin sequencer (top).
// Pulls the open-drain reset pin low for ASSERT_CYC cycles on any request,
// releases it, samples it SETTLE_CYC and then RECHECK_CYC cycles later, and
// retries the assertion if it stays low. After power-on it waits for clock
// lock unless the external clock mode is selected.
// Assumes pll_lock, ext_clk_mode, int_req, cfg_in and cause_clr are
// synchronous to clk; pin_in is asynchronous.
module rst_pin_seq
    import rst_seq_pkg::*;
#(
    parameter int ASSERT_CYC  = 512,
    parameter int SETTLE_CYC  = 10,
    parameter int RECHECK_CYC = 180,
    parameter int SYNC_STAGES = 2,
    parameter int CFG_W       = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pll_lock,
    input  logic               ext_clk_mode,
    input  logic               int_req,
    input  logic               pin_in,
    input  logic [CFG_W-1:0]   cfg_in,
    input  logic               cause_clr,
    output logic               pin_oe,
    output logic               sys_rst_n,
    output logic               bus_en,
    output logic               fetch_start,
    output logic [CFG_W-1:0]   cfg_q,
    output logic [CAUSE_W-1:0] cause
);

    localparam int MAX_AB = (ASSERT_CYC > SETTLE_CYC) ? ASSERT_CYC : SETTLE_CYC;
    localparam int MAX_CYC = (MAX_AB > RECHECK_CYC) ? MAX_AB : RECHECK_CYC;
    localparam int CNT_W = $clog2(MAX_CYC + 1);

    seq_state_t         state_q, state_d;
    logic               pin_s;
    logic               win_done;
    logic               win_restart;
    logic [CNT_W-1:0]   win_last;
    logic [CAUSE_W-1:0] cause_set;
    logic               fetch_q;
    logic [CFG_W-1:0]   cfg_r;

    rst_pin_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (pin_in),
        .d_out (pin_s)
    );

    // Pick the last count of the window for the current state.
    always_comb begin
        case (state_q)
            ST_ASSERT:  win_last = CNT_W'(ASSERT_CYC - 1);
            ST_SETTLE:  win_last = CNT_W'(SETTLE_CYC - 1);
            ST_RECHECK: win_last = CNT_W'(RECHECK_CYC - 1);
            default:    win_last = '0;
        endcase
    end

    assign win_restart = (state_d != state_q);

    rst_win_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (win_restart),
        .last    (win_last),
        .done    (win_done)
    );

    // Next-state and cause-set decode for the sequencer.
    always_comb begin
        state_d   = state_q;
        cause_set = '0;
        case (state_q)
            ST_LOCK: begin
                if (pll_lock || ext_clk_mode) begin
                    state_d = ST_ASSERT;
                end
            end
            ST_ASSERT: begin
                if (win_done) begin
                    state_d = ST_SETTLE;
                end
            end
            ST_SETTLE: begin
                if (win_done) begin
                    state_d = pin_s ? ST_RUN : ST_RECHECK;
                end
            end
            ST_RECHECK: begin
                if (win_done) begin
                    if (pin_s) begin
                        state_d = ST_RUN;
                    end else begin
                        state_d              = ST_ASSERT;
                        cause_set[CAUSE_EXT] = 1'b1;
                    end
                end
            end
            ST_RUN: begin
                if (int_req) begin
                    state_d              = ST_ASSERT;
                    cause_set[CAUSE_INT] = 1'b1;
                end else if (!pin_s) begin
                    state_d              = ST_ASSERT;
                    cause_set[CAUSE_EXT] = 1'b1;
                end
            end
            default: state_d = ST_LOCK;
        endcase
    end

    // State register and the registered fetch-start pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_LOCK;
            fetch_q <= 1'b0;
        end else begin
            state_q <= state_d;
            fetch_q <= (state_d == ST_RUN) && (state_q != ST_RUN);
        end
    end

    // Capture the configuration word on the release edge only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_r <= '0;
        end else if ((state_q == ST_ASSERT) && win_done) begin
            cfg_r <= cfg_in;
        end
    end

    rst_cause_reg #(
        .W       (CAUSE_W),
        .POR_BIT (CAUSE_POR)
    ) u_cause (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (cause_set),
        .clr   (cause_clr),
        .cause (cause)
    );

    assign pin_oe      = (state_q == ST_LOCK) || (state_q == ST_ASSERT);
    assign sys_rst_n   = !pin_oe;
    assign bus_en      = (state_q == ST_RUN);
    assign fetch_start = fetch_q;
    assign cfg_q       = cfg_r;

endmodule

// File: rtl/rst_pin_seq_chk.sv
// Module: property checker for rst_pin_seq, attached through bind.
// Assumes it sees only the top-level ports of the sequencer.
module rst_pin_seq_chk #(
    parameter int ASSERT_CYC = 512,
    parameter int CFG_W      = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             int_req,
    input logic             cause_clr,
    input logic             pin_oe,
    input logic             sys_rst_n,
    input logic             bus_en,
    input logic             fetch_start,
    input logic [CFG_W-1:0] cfg_q,
    input logic [2:0]       cause
);

    int unsigned oe_run;

    // Length of the current stretch of pin drive, in cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_run <= 0;
        end else if (pin_oe) begin
            if (oe_run < 32'hFFFF_FFF0) oe_run <= oe_run + 1;
        end else begin
            oe_run <= 0;
        end
    end

    // R3
    assert_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pin_oe) |-> (oe_run >= ASSERT_CYC));

    // R4
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_q) |-> $fell(pin_oe));

    // R5
    fetch_with_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_en) |-> fetch_start);

    // R5
    fetch_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_start |=> !fetch_start);

    // R8
    int_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cause[1]) |-> $rose(pin_oe));

    // R10
    int_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(int_req) && !$past(bus_en)) |-> ($past(cause[1]) || !cause[1]));

    // R11
    cause_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cause) & ~cause) != 3'b000 |-> $past(cause_clr));

    // R12
    core_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pin_oe |-> !sys_rst_n);

    // R12
    bus_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_en |-> !pin_oe);

    // R12
    core_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst_n) |-> (!$past(sys_rst_n, 2) && !$past(sys_rst_n, 3)
                              && !$past(sys_rst_n, 4)));

endmodule

bind rst_pin_seq rst_pin_seq_chk #(
    .ASSERT_CYC (ASSERT_CYC),
    .CFG_W      (CFG_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .int_req     (int_req),
    .cause_clr   (cause_clr),
    .pin_oe      (pin_oe),
    .sys_rst_n   (sys_rst_n),
    .bus_en      (bus_en),
    .fetch_start (fetch_start),
    .cfg_q       (cfg_q),
    .cause       (cause)
);

// File: tb/tb_rst_pin_seq.sv
// Bench: scoreboard for rst_pin_seq. Driver tasks queue the pin and fetch
// events the requirements predict; a negedge monitor pops and compares.
module tb_rst_pin_seq;

    localparam int A_CYC = 512;
    localparam int S_CYC = 10;
    localparam int R_CYC = 180;
    localparam int EV_RISE  = 0;
    localparam int EV_FALL  = 1;
    localparam int EV_FETCH = 2;

    typedef struct {
        int    kind;
        int    at;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pll_lock = 1'b0;
    logic       ext_clk_mode = 1'b0;
    logic       int_req = 1'b0;
    logic       ext_low = 1'b0;
    logic [3:0] cfg_in = 4'h0;
    logic       cause_clr = 1'b0;
    logic       pin_oe, sys_rst_n, bus_en, fetch_start;
    logic [3:0] cfg_q;
    logic [2:0] cause;
    wire        pin_in = !pin_oe && !ext_low;

    int   cyc = 0;
    int   n_chk = 0;
    int   n_err = 0;
    bit   mon_en = 1'b0;
    logic prev_oe = 1'b1;
    exp_t sb[$];

    rst_pin_seq dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .pll_lock     (pll_lock),
        .ext_clk_mode (ext_clk_mode),
        .int_req      (int_req),
        .pin_in       (pin_in),
        .cfg_in       (cfg_in),
        .cause_clr    (cause_clr),
        .pin_oe       (pin_oe),
        .sys_rst_n    (sys_rst_n),
        .bus_en       (bus_en),
        .fetch_start  (fetch_start),
        .cfg_q        (cfg_q),
        .cause        (cause)
    );

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic push(input int kind, input int at, input string tag);
        exp_t e;
        e.kind = kind;
        e.at   = at;
        e.tag  = tag;
        sb.push_back(e);
    endtask

    task automatic observe(input int kind);
        exp_t e;
        if (sb.size() == 0) begin
            check(1'b0, "R3", "unexpected event kind*1e6+cycle", kind * 1000000 + cyc, -1);
        end else begin
            e = sb.pop_front();
            check((e.kind == kind) && (e.at == cyc), e.tag, "event kind*1e6+cycle",
                  kind * 1000000 + cyc, e.kind * 1000000 + e.at);
        end
    endtask

    // Monitor: stamp each pin edge and fetch pulse with the edge count.
    always @(negedge clk) begin
        if (mon_en) begin
            if (pin_oe && !prev_oe) observe(EV_RISE);
            if (!pin_oe && prev_oe) observe(EV_FALL);
            if (fetch_start) observe(EV_FETCH);
            prev_oe = pin_oe;
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_cause();
        cause_clr = 1'b1;
        idle(1);
        cause_clr = 1'b0;
        idle(1);
    endtask

    task automatic pulse_int();
        int_req = 1'b1;
        idle(1);
        int_req = 1'b0;
    endtask

    task automatic finish_run();
        check(sb.size() == 0, "R5", "events left in scoreboard", sb.size(), 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "R1", "watchdog expired at cycle", cyc, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int c;
        idle(3);
        // R1: reset state.
        check(pin_oe == 1'b1, "R1", "pin_oe in reset", pin_oe, 1);
        check(sys_rst_n == 1'b0, "R1", "sys_rst_n in reset", sys_rst_n, 0);
        check(bus_en == 1'b0 && fetch_start == 1'b0, "R1", "bus_en|fetch in reset",
              bus_en | fetch_start, 0);
        check(cause == 3'b001, "R1", "cause after reset", cause, 1);

        // R1: no lock, no external clock: pin stays held.
        rst_n = 1'b1;
        prev_oe = 1'b1;
        mon_en = 1'b1;
        idle(40);
        check(pin_oe == 1'b1, "R1", "pin_oe while waiting for lock", pin_oe, 1);

        // R3 R5 R4: lock arrives; cfg captured at release only.
        cfg_in = 4'hA;
        pll_lock = 1'b1;
        c = cyc;
        push(EV_FALL, c + 1 + A_CYC, "R3");
        push(EV_FETCH, c + 1 + A_CYC + S_CYC, "R5");
        idle(100);
        check(sys_rst_n == 1'b0, "R12", "sys_rst_n during assertion", sys_rst_n, 0);
        idle(A_CYC + 1 - 100 + 2);
        cfg_in = 4'h5;
        check(bus_en == 1'b0, "R12", "bus_en before sample", bus_en, 0);
        idle(20);
        check(bus_en == 1'b1, "R5", "bus_en after good sample", bus_en, 1);
        check(sys_rst_n == 1'b1, "R12", "sys_rst_n in run", sys_rst_n, 1);
        check(cfg_q == 4'hA, "R4", "cfg_q captured at release", cfg_q, 4'hA);
        idle(5);
        check(cfg_q == 4'hA, "R4", "cfg_q after cfg_in change in run", cfg_q, 4'hA);

        // R11: clear.
        clear_cause();
        check(cause == 3'b000, "R11", "cause after clear", cause, 0);

        // R8: internal request in run.
        c = cyc;
        push(EV_RISE, c + 1, "R8");
        push(EV_FALL, c + 1 + A_CYC, "R3");
        push(EV_FETCH, c + 1 + A_CYC + S_CYC, "R5");
        pulse_int();
        idle(A_CYC + S_CYC + 10);
        check(cause == 3'b010, "R8", "cause after internal request", cause, 2);
        check(cfg_q == 4'h5, "R4", "cfg_q at second release", cfg_q, 5);

        // R9 R10: external pin low in run; int_req during settle ignored.
        clear_cause();
        c = cyc;
        push(EV_RISE, c + 3, "R9");
        push(EV_FALL, c + 3 + A_CYC, "R3");
        push(EV_FETCH, c + 3 + A_CYC + S_CYC, "R10");
        ext_low = 1'b1;
        idle(5);
        ext_low = 1'b0;
        idle(A_CYC + 3 - 5 + 2);
        pulse_int();
        idle(S_CYC + 10);
        check(cause == 3'b100, "R10", "cause after ext reset, ignored int_req", cause, 4);

        // R6: pin low at first sample, high at second.
        clear_cause();
        c = cyc;
        push(EV_RISE, c + 1, "R8");
        push(EV_FALL, c + 1 + A_CYC, "R3");
        push(EV_FETCH, c + 1 + A_CYC + S_CYC + R_CYC, "R6");
        pulse_int();
        ext_low = 1'b1;
        idle(A_CYC + S_CYC + 6);
        ext_low = 1'b0;
        idle(R_CYC + 10);
        check(bus_en == 1'b1, "R6", "bus_en after second sample", bus_en, 1);

        // R7: pin low at both samples, retry, then recover.
        clear_cause();
        c = cyc;
        push(EV_RISE, c + 1, "R8");
        push(EV_FALL, c + 1 + A_CYC, "R3");
        push(EV_RISE, c + 1 + A_CYC + S_CYC + R_CYC, "R7");
        push(EV_FALL, c + 1 + 2 * A_CYC + S_CYC + R_CYC, "R7");
        push(EV_FETCH, c + 1 + 2 * A_CYC + 2 * S_CYC + R_CYC, "R7");
        pulse_int();
        ext_low = 1'b1;
        idle(A_CYC + S_CYC + R_CYC + 100);
        ext_low = 1'b0;
        idle(A_CYC + S_CYC + 20);
        check(cause == 3'b110, "R7", "cause after retry", cause, 6);

        // R2: external clock mode bypasses the lock wait.
        mon_en = 1'b0;
        rst_n = 1'b0;
        pll_lock = 1'b0;
        ext_clk_mode = 1'b1;
        idle(3);
        check(cause == 3'b001, "R1", "cause after second power-on", cause, 1);
        rst_n = 1'b1;
        c = cyc;
        prev_oe = 1'b1;
        mon_en = 1'b1;
        push(EV_FALL, c + 1 + A_CYC, "R2");
        push(EV_FETCH, c + 1 + A_CYC + S_CYC, "R2");
        idle(A_CYC + S_CYC + 10);

        // R11: set wins over clear in the same cycle.
        c = cyc;
        push(EV_RISE, c + 1, "R8");
        push(EV_FALL, c + 1 + A_CYC, "R3");
        push(EV_FETCH, c + 1 + A_CYC + S_CYC, "R5");
        cause_clr = 1'b1;
        pulse_int();
        cause_clr = 1'b0;
        check(cause == 3'b010, "R11", "cause when set meets clear", cause, 2);
        idle(A_CYC + S_CYC + 10);

        finish_run();
    end

endmodule